// File: doc/BRIEF.md
# Column-Bypassing Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It is built as a carry-save adder array followed by a ripple adder that resolves the carries. Every adder cell in the array belongs to one column, and each column is tied to one bit of the multiplicand. When that bit is zero, every partial product in the column is zero. The cell then forces its operand and carry inputs to constant zero, and a 2-to-1 multiplexer sends the sum from the cell above straight down. The disabled adder therefore does not toggle, and the product is still exact.

The product and the column enable vector are registered once at the top, so a result appears one clock edge after its operands. The enable vector shows which columns were active for that result. The carries leaving the last carry-save row are ANDed with their column enable before they enter the final adder.

Top module: `colbyp_mult`

## Requirements
- R1: At N = 4, `product` equals `a_in * b_in` for every one of the 256 operand pairs. The result appears one rising clock edge after the operands are presented.
- R2: At N = 8 and N = 16, `product` equals `a_in * b_in` one edge later.
- R3: `col_en` bit i equals bit i of the multiplicand that was registered at the same edge as `product`, where 1 means column i was active.
- R4: A zero multiplicand bypasses every column and gives a zero product for any multiplier value.
- R5: A multiplicand with a single bit k set leaves only column k active, and the product equals `b_in` shifted left by k.
- R6: No last-row carry leaves a column whose multiplicand bit is zero. Multiplicands that mix zero and one bits, with a multiplier of all ones, still give exact products.
- R7: While `rst_n` is low, `product` and `col_en` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | N | Multiplicand. Each bit enables one column |
| b_in | input | N | Multiplier |
| product | output | 2N | Registered product |
| col_en | output | N | Registered column enables (1 = column active) |

## Verification
The hardest case to reach from the ports is a bypassed column sitting next to active columns while the multiplier is dense. Only in that case would an unmasked or stray carry from the disabled column corrupt the product. The stimulus therefore includes multiplicands with isolated and alternating zero bits, each paired with an all-ones multiplier, and the exhaustive N = 4 sweep covers every such placement. A bound checker also watches the raw last-row carries directly and requires them to be zero in every bypassed column.

// File: rtl/colbyp_pkg.sv
package colbyp_pkg;
   // width of the full product for an n-bit by n-bit multiply
   function automatic int unsigned prod_width(input int unsigned n);
      return 2 * n;
   endfunction
endpackage

// File: rtl/colbyp_cell.sv
module colbyp_cell (
   input  logic en,
   input  logic pp,
   input  logic s_in,
   input  logic c_in,
   output logic s_out,
   output logic c_out
);
   logic x_iso, c_iso, fa_s, fa_c;

   // operand isolation: a disabled column sees constant zero
   assign x_iso = pp & en;
   assign c_iso = c_in & en;

   assign fa_s = x_iso ^ s_in ^ c_iso;
   assign fa_c = (x_iso & s_in) | (x_iso & c_iso) | (s_in & c_iso);

   // sum-through multiplexer
   assign s_out = en ? fa_s : s_in;
   assign c_out = fa_c & en;
endmodule

// File: rtl/colbyp_ripple.sv
module colbyp_ripple #(
   parameter int unsigned W = 3
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] s,
   output logic         co
);
   logic [W:0] c;
   assign c[0] = 1'b0;
   for (genvar k = 0; k < W; k++) begin : g_bit
      assign s[k]   = x[k] ^ y[k] ^ c[k];
      assign c[k+1] = (x[k] & y[k]) | (x[k] & c[k]) | (y[k] & c[k]);
   end
   assign co = c[W];
endmodule

// File: rtl/colbyp_array.sv
module colbyp_array #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic [2*N-1:0] p,
   output logic [N-2:0]   last_carry
);
   localparam int unsigned CW = N - 1;

   logic [N-1:0][N-1:0]  pp;   // pp[row j][column i] = a[i] & b[j]
   logic [N-1:1][CW-1:0] sm;
   logic [N-1:1][CW-1:0] cr;
   logic [CW-1:0]        fx, fy, fs;
   logic                 fco;

   for (genvar j = 0; j < N; j++) begin : g_pp
      assign pp[j] = a & {N{b[j]}};
   end

   for (genvar j = 1; j < N; j++) begin : g_row
      for (genvar i = 0; i < CW; i++) begin : g_col
         logic s_src, c_src;
         if (i == CW - 1) begin : g_edge
            assign s_src = pp[j-1][N-1];
         end else if (j == 1) begin : g_top
            assign s_src = pp[0][i+1];
         end else begin : g_mid
            assign s_src = sm[j-1][i+1];
         end
         if (j == 1) begin : g_c0
            assign c_src = 1'b0;
         end else begin : g_cn
            assign c_src = cr[j-1][i];
         end
         colbyp_cell u_cell (
            .en   (a[i]),
            .pp   (pp[j][i]),
            .s_in (s_src),
            .c_in (c_src),
            .s_out(sm[j][i]),
            .c_out(cr[j][i])
         );
      end
      assign p[j] = sm[j][0];
   end
   assign p[0] = pp[0][0];

   for (genvar k = 0; k < CW; k++) begin : g_fin
      if (k == CW - 1) begin : g_hi
         assign fx[k] = pp[N-1][N-1];
      end else begin : g_lo
         assign fx[k] = sm[N-1][k+1];
      end
      // mask: a bypassed column injects no carry into the final adder
      assign fy[k] = cr[N-1][k] & a[k];
   end

   colbyp_ripple #(.W(CW)) u_final (
      .x (fx),
      .y (fy),
      .s (fs),
      .co(fco)
   );

   assign p[2*N-2:N] = fs;
   assign p[2*N-1]   = fco;
   assign last_carry = cr[N-1];
endmodule

// File: rtl/colbyp_mult.sv
module colbyp_mult #(
   parameter int unsigned N = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [N-1:0]                           a_in,
   input  logic [N-1:0]                           b_in,
   output logic [colbyp_pkg::prod_width(N)-1:0]   product,
   output logic [N-1:0]                           col_en
);
   localparam int unsigned PW = colbyp_pkg::prod_width(N);

   if (N < 2) begin : g_bad_n
      $error("colbyp_mult: N must be at least 2");
   end

   logic [PW-1:0] p_comb;
   logic [N-2:0]  tail_carry;

   colbyp_array #(.N(N)) u_array (
      .a         (a_in),
      .b         (b_in),
      .p         (p_comb),
      .last_carry(tail_carry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         product <= '0;
         col_en  <= '0;
      end else begin
         product <= p_comb;
         col_en  <= a_in;
      end
   end
endmodule

// File: rtl/colbyp_mult_chk.sv
module colbyp_mult_chk #(
   parameter int unsigned N = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic [N-1:0]   a_in,
   input logic [N-1:0]   b_in,
   input logic [2*N-1:0] product,
   input logic [N-1:0]   col_en,
   input logic [N-2:0]   tail_carry
);
   logic [2*N-1:0] a_ext, b_ext;
   logic           primed;

   assign a_ext = {{N{1'b0}}, a_in};
   assign b_ext = {{N{1'b0}}, b_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> product == $past(a_ext) * $past(b_ext)); // R1

   AST_ENABLE_TRACKS_A: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> col_en == $past(a_in)); // R3

   AST_ALL_BYPASSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && col_en == '0) |-> product == '0); // R4

   AST_SINGLE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $countones(col_en) == 1) |-> product == ($past(b_ext) << $clog2(col_en))); // R5

   AST_NO_BYPASSED_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_carry & ~a_in[N-2:0]) == '0); // R6

   always_comb begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (product == '0 && col_en == '0); // R7
      end
   end
endmodule

bind colbyp_mult colbyp_mult_chk #(.N(N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .a_in      (a_in),
   .b_in      (b_in),
   .product   (product),
   .col_en    (col_en),
   .tail_carry(tail_carry)
);

// File: tb/sim_colbyp_mult.sv
module sim_colbyp_mult;
   localparam int unsigned PERIOD = 20;

   typedef struct {
      logic [7:0]  e4;
      logic [3:0]  en4;
      logic [15:0] e8;
      logic [31:0] e16;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  a4 = '0, b4 = '0;
   logic [7:0]  a8 = '0, b8 = '0;
   logic [15:0] a16 = '0, b16 = '0;
   logic [7:0]  p4;
   logic [3:0]  c4;
   logic [15:0] p8;
   logic [7:0]  c8;
   logic [31:0] p16;
   logic [15:0] c16;

   int checks = 0;
   int errors = 0;
   item_t sb[$];
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   colbyp_mult #(.N(4))  u0 (.clk(clk), .rst_n(rst_n), .a_in(a4),  .b_in(b4),  .product(p4),  .col_en(c4));
   colbyp_mult #(.N(8))  u1 (.clk(clk), .rst_n(rst_n), .a_in(a8),  .b_in(b8),  .product(p8),  .col_en(c8));
   colbyp_mult #(.N(16)) u2 (.clk(clk), .rst_n(rst_n), .a_in(a16), .b_in(b16), .product(p16), .col_en(c16));

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // driver: applies operands at a falling edge and queues the expected results
   task automatic drive(input logic [3:0] xa4, input logic [3:0] xb4,
                        input logic [7:0] xa8, input logic [7:0] xb8,
                        input logic [15:0] xa16, input logic [15:0] xb16,
                        input string tag);
      item_t it;
      @(negedge clk);
      a4 = xa4; b4 = xb4; a8 = xa8; b8 = xb8; a16 = xa16; b16 = xb16;
      it.e4  = 8'(xa4) * 8'(xb4);
      it.en4 = xa4;
      it.e8  = 16'(xa8) * 16'(xb8);
      it.e16 = 32'(xa16) * 32'(xb16);
      it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: one queued item resolves per rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(p4 == it.e4, it.tag, 32'(p4), 32'(it.e4));
            check(c4 == it.en4, "R3", 32'(c4), 32'(it.en4));
            check(p8 == it.e8, "R2", 32'(p8), 32'(it.e8));
            check(p16 == it.e16, "R2", p16, it.e16);
         end
      end
   end

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
      end
   end

   initial begin
      a4 = 4'hF; b4 = 4'hF; a8 = 8'hFF; b8 = 8'hFF; a16 = 16'hFFFF; b16 = 16'hFFFF;
      repeat (3) @(negedge clk);
      // R7: outputs held at zero in reset even with live operands
      check(p4 == '0 && p16 == '0, "R7", 32'(p4), 32'h0);
      check(c4 == '0 && c16 == '0, "R7", 32'(c4), 32'h0);
      rst_n = 1'b1;

      // R1: exhaustive sweep at N = 4, random wide operands alongside (R2)
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            drive(4'(x), 4'(y), 8'($urandom), 8'($urandom),
                  16'($urandom), 16'($urandom), "R1");
         end
      end
      // R4: zero multiplicand bypasses every column
      drive(4'h0, 4'hF, 8'h00, 8'hFF, 16'h0000, 16'hFFFF, "R4");
      drive(4'h0, 4'hA, 8'h00, 8'h5A, 16'h0000, 16'h1234, "R4");
      // R5: one active column, product is a shifted multiplier
      for (int k = 0; k < 4; k++) begin
         drive(4'(1 << k), 4'hB, 8'(1 << (2*k+1)), 8'hC7,
               16'(1 << (4*k+3)), 16'hBEEF, "R5");
      end
      // R6: isolated and alternating zero columns against dense multipliers
      drive(4'b1011, 4'hF, 8'b1011_0111, 8'hFF, 16'hEFF7, 16'hFFFF, "R6");
      drive(4'b0101, 4'hF, 8'b0101_0101, 8'hFF, 16'h5555, 16'hFFFF, "R6");
      drive(4'b1010, 4'hF, 8'b1010_1010, 8'hFF, 16'hAAAA, 16'hFFFF, "R6");
      drive(4'b1101, 4'hF, 8'b1111_1110, 8'hFF, 16'h7FFF, 16'hFFFF, "R6");
      drive(4'hF, 4'hF, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, "R6");
      // R2: more random wide vectors
      for (int r = 0; r < 200; r++) begin
         drive(4'($urandom), 4'($urandom), 8'($urandom), 8'($urandom),
               16'($urandom), 16'($urandom), "R1");
      end
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R1", 32'(sb.size()), 32'h0);
      done = 1'b1;
      summary();
   end
endmodule